// File: doc/BRIEF.md
# Scanline Area Fill Unit

This block is a streaming post-processor that turns an outline bitmap into filled regions. It takes one 16-bit destination word per cycle. Words arrive in descending order: right to left along each row. Two strobes mark the first word and the last word of a row. A single fill carry bit runs across the row from bit 0 toward the top bit of each word. It crosses from one word into the next, and it flips at every set outline bit. As a result, the span between each pair of outline bits on a row is filled.

Two output rules are available. Inclusive fill keeps both edge bits set. Exclusive fill clears the left edge bit, so shapes that touch do not overlap. When neither rule is enabled, words pass through unchanged. The whole word is resolved in one cycle by a carry chain, and the result appears on registered outputs one cycle after the word is accepted.

Top module: `scanline_fill`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_word` to 0 and clears the held carry. A reset that arrives while a word is being accepted still leaves `out_valid` at 0 after the edge.
- R2: Every word accepted with `in_valid`=1 produces `out_valid`=1 on the next cycle, with `out_row_last` equal to the accepted `row_last`. A cycle with `in_valid`=0 produces `out_valid`=0 on the next cycle.
- R3: With `incl_en`=0 and `excl_en`=0, `out_word` equals the accepted word.
- R4: Inclusive mode (`incl_en`=1): bit i of the output is `in_word[i]` OR the carry in effect before bit i. Bits are taken in order from bit 0 to bit 15, and the carry flips after each set bit.
- R5: Exclusive mode (`excl_en`=1, `incl_en`=0): bit i of the output is the carry after bit i has flipped it.
- R6: When both `incl_en` and `excl_en` are 1, the inclusive rule applies.
- R7: On a word with `row_first`=1, the carry entering bit 0 is `carry_seed`, whatever state the previous row ended in. On any other word, `carry_seed` has no effect.
- R8: The carry that leaves bit 15 of one word enters bit 0 of the next accepted word in the same row. Cycles with `in_valid`=0 leave it unchanged, even if the other inputs change.
- R9: With `carry_seed`=1, a row starts inside a filled span. An all-zero word then produces all ones in both fill modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 16 | Outline word; bit 0 is the rightmost pixel |
| row_first | input | 1 | Word is the first (rightmost) word of a row |
| row_last | input | 1 | Word is the last (leftmost) word of a row |
| incl_en | input | 1 | Select the inclusive fill rule |
| excl_en | input | 1 | Select the exclusive fill rule |
| carry_seed | input | 1 | Carry value loaded at the start of each row |
| out_valid | output | 1 | Filled word is present this cycle |
| out_word | output | 16 | Filled word |
| out_row_last | output | 1 | Registered copy of `row_last` |

## Verification
The assertions assume that a row begins with a word that carries `row_first`. They also assume that words are presented right to left, and that `in_word` and the mode inputs are defined whenever `in_valid` is high. The mode inputs are only sampled together with a word.

The stimulus obeys these assumptions. It marks the first word of every row, including one-word rows. It changes the mode inputs only at the start of a row. Its idle gaps hold `in_valid` low, and during those gaps it deliberately drives misleading data and strobes.

// File: rtl/sfill_pkg.sv
package sfill_pkg;

  typedef enum logic [1:0] {
    FILL_PASS = 2'd0,
    FILL_INCL = 2'd1,
    FILL_EXCL = 2'd2
  } fill_mode_e;

  // inclusive rule outranks exclusive
  function automatic fill_mode_e decode_mode(input logic incl, input logic excl);
    if (incl)      return FILL_INCL;
    else if (excl) return FILL_EXCL;
    else           return FILL_PASS;
  endfunction

endpackage

// File: rtl/sfill_chain.sv
module sfill_chain #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] in_word,
  input  logic              carry_in,
  output logic [WORD_W-1:0] c_before,
  output logic [WORD_W-1:0] c_after,
  output logic              carry_out
);

  logic [WORD_W:0] link;

  assign link[0] = carry_in;

  for (genvar i = 0; i < WORD_W; i++) begin : g_stage
    assign link[i+1]   = link[i] ^ in_word[i];
    assign c_before[i] = link[i];
    assign c_after[i]  = link[i+1];
  end

  assign carry_out = link[WORD_W];

endmodule

// File: rtl/sfill_pick.sv
module sfill_pick #(
  parameter int WORD_W = 16
) (
  input  sfill_pkg::fill_mode_e mode,
  input  logic [WORD_W-1:0]     in_word,
  input  logic [WORD_W-1:0]     c_before,
  input  logic [WORD_W-1:0]     c_after,
  output logic [WORD_W-1:0]     filled
);
  import sfill_pkg::*;

  always_comb begin
    unique case (mode)
      FILL_INCL: filled = in_word | c_before;
      FILL_EXCL: filled = c_after;
      default:   filled = in_word;
    endcase
  end

endmodule

// File: rtl/sfill_carry.sv
module sfill_carry (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic row_first,
  input  logic carry_seed,
  input  logic chain_out,
  output logic carry_in
);

  logic carry_q;

  assign carry_in = row_first ? carry_seed : carry_q;

  always_ff @(posedge clk) begin
    if (rst)           carry_q <= 1'b0;
    else if (in_valid) carry_q <= chain_out;
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(carry_q));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !carry_q);

endmodule

// File: rtl/scanline_fill.sv
module scanline_fill #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              row_first,
  input  logic              row_last,
  input  logic              incl_en,
  input  logic              excl_en,
  input  logic              carry_seed,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_row_last
);
  import sfill_pkg::*;

  localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

  fill_mode_e        mode;
  logic              carry_in;
  logic              carry_out;
  logic [WORD_W-1:0] c_before;
  logic [WORD_W-1:0] c_after;
  logic [WORD_W-1:0] filled;

  assign mode = decode_mode(incl_en, excl_en);

  sfill_carry u_carry (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .row_first  (row_first),
    .carry_seed (carry_seed),
    .chain_out  (carry_out),
    .carry_in   (carry_in)
  );

  sfill_chain #(.WORD_W(WORD_W)) u_chain (
    .in_word   (in_word),
    .carry_in  (carry_in),
    .c_before  (c_before),
    .c_after   (c_after),
    .carry_out (carry_out)
  );

  sfill_pick #(.WORD_W(WORD_W)) u_pick (
    .mode     (mode),
    .in_word  (in_word),
    .c_before (c_before),
    .c_after  (c_after),
    .filled   (filled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_row_last <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word     <= filled;
        out_row_last <= row_last;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));

  // R2
  word_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_row_last == $past(row_last)));

  // R2
  no_word_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !incl_en && !excl_en) |=> out_word == $past(in_word));

  // R4
  incl_keeps_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && incl_en) |=> (out_word & $past(in_word)) == $past(in_word));

  // R5
  excl_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && excl_en && !incl_en && in_word == '0)
      |=> (out_word == '0 || out_word == ALL_ONES));

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && row_first && incl_en && in_word == '0)
      |=> out_word == (($past(carry_seed)) ? ALL_ONES : '0));

endmodule

// File: tb/sim_scanline_fill.sv
`timescale 1ns/1ps
module sim_scanline_fill;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        row_first = 1'b0;
  logic        row_last = 1'b0;
  logic        incl_en = 1'b0;
  logic        excl_en = 1'b0;
  logic        carry_seed = 1'b0;
  logic        out_valid;
  logic [15:0] out_word;
  logic        out_row_last;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanline_fill u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .row_first(row_first), .row_last(row_last), .incl_en(incl_en),
    .excl_en(excl_en), .carry_seed(carry_seed), .out_valid(out_valid),
    .out_word(out_word), .out_row_last(out_row_last)
  );

  // entry: {first, last, incl, excl, seed, word[15:0], expected[15:0]}
  localparam int N = 18;
  localparam logic [36:0] VEC [N] = '{
    {5'b11000, 16'h1234, 16'h1234},  // R3 pass
    {5'b11100, 16'h0810, 16'h0FF0},  // R4 inclusive
    {5'b11010, 16'h0810, 16'h07F0},  // R5 exclusive
    {5'b11110, 16'h0810, 16'h0FF0},  // R6 both set
    {5'b10100, 16'h8000, 16'h8000},  // R8 row start
    {5'b01100, 16'h0100, 16'h01FF},  // R8 carry crosses word
    {5'b10010, 16'h8000, 16'h8000},  // R8 exclusive start
    {5'b01010, 16'h0100, 16'h00FF},  // R8 exclusive crossing
    {5'b11101, 16'h0000, 16'hFFFF},  // R9 inclusive seed
    {5'b11011, 16'h0000, 16'hFFFF},  // R9 exclusive seed
    {5'b11011, 16'h0001, 16'h0000},  // R9 exclusive edge
    {5'b11101, 16'h0001, 16'h0001},  // R9 inclusive edge
    {5'b11100, 16'h8000, 16'h8000},  // R7 row ends with carry 1
    {5'b11100, 16'h0000, 16'h0000},  // R7 reload from seed
    {5'b10100, 16'h0000, 16'h0000},  // R7 start
    {5'b01101, 16'h0000, 16'h0000},  // R7 seed ignored mid-row
    {5'b11010, 16'h0909, 16'h0707},  // R5 two spans
    {5'b11100, 16'h0909, 16'h0F0F}   // R4 two spans
  };
  localparam int TAG [N] = '{3,4,5,6,8,8,8,8,9,9,9,9,7,7,7,7,5,4};

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic f, input logic l, input logic inc,
                      input logic exc, input logic sd, input logic [15:0] w);
    in_valid = 1'b1; row_first = f; row_last = l;
    incl_en = inc; excl_en = exc; carry_seed = sd; in_word = w;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {31'd0, out_valid}, 32'd0);
    check(1, {16'd0, out_word}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < N; k++) begin
      send(VEC[k][36], VEC[k][35], VEC[k][34], VEC[k][33], VEC[k][32], VEC[k][31:16]);
      check(TAG[k], {16'd0, out_word}, {16'd0, VEC[k][15:0]});
      check(2, {31'd0, out_valid}, 32'd1);                       // R2
      check(2, {31'd0, out_row_last}, {31'd0, VEC[k][35]});       // R2
    end

    // R8: idle cycles with misleading inputs must not disturb the carry
    send(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8000);
    check(8, {16'd0, out_word}, 32'h8000);
    in_valid = 1'b0; in_word = 16'hFFFF; row_first = 1'b1; carry_seed = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(2, {31'd0, out_valid}, 32'd0);  // R2 idle
    end
    send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100);
    check(8, {16'd0, out_word}, 32'h01FF);

    // R1 reset during an accepted word
    rst = 1'b1;
    send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hABCD);
    check(1, {31'd0, out_valid}, 32'd0);
    check(1, {16'd0, out_word}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  end

endmodule